// File: doc/BRIEF.md
# UART Channel Loopback Mode Router

This block sits between the serial pins of one UART channel and that channel's transmitter and receiver cores. A two-bit mode selects how it routes serial data, the per-bit clock enables, the character strobes and the status flags between the pins, the cores and the CPU-side FIFOs. The four modes are normal operation, automatic echo, local loop and remote loop.

In the two echo modes the router samples the received line once per receive bit and drives the bit back out on TxD one bit period later. The stream is passed on unchanged, so parity and stop bits go out exactly as they arrived. A break that the receiver reports holds TxD low until the receiver signals the next valid start bit. In local loop the transmitter's serial output feeds the receiver, and the receiver is clocked by the transmitter's bit enable. The pin is held at mark and the RxD pin is ignored. A new mode value is accepted only while both cores are idle. Until then the router keeps the previous mode.

Top module: `uart_loop_router`

## Requirements
- R1: Mode codes are 2'b00 normal, 2'b01 automatic echo, 2'b10 local loop and 2'b11 remote loop. Reset selects normal. `mode_o` reports the active mode.
- R2: `mode_cfg_i` is loaded into the active mode at a clock edge only when `tx_busy_i` and `rx_busy_i` are both low. At any other edge the active mode is kept.
- R3: In normal mode every signal passes straight through. `txd_o`=`tx_ser_i`, `rx_ser_o`=`rxd_i` and `rx_tick_o`=`rx_tick_i`. The write strobe, push strobe, ready/idle flags and error flags are forwarded unchanged, and `rx_chk_en_o`=1.
- R4: In local loop, `txd_o`=1, `rx_ser_o`=`tx_ser_i` and `rx_tick_o`=`tx_tick_i`. `rxd_i` has no effect on any output. The CPU strobes and the status and error flags pass through.
- R5: In both echo modes `rx_ser_o`=`rxd_i` and `rx_tick_o`=`rx_tick_i`. At each clock edge with `rx_tick_i` high, the router samples `rxd_i`, and `txd_o` takes the value that was sampled at the previous such edge. The sample registers reset to 1.
- R6: In automatic echo, `tx_fifo_wr_o`, `tx_rdy_o` and `tx_idle_o` are 0. `rx_push_o` and `rx_err_o` pass through, and `rx_chk_en_o`=1.
- R7: In remote loop, `rx_push_o`=0, `rx_err_o`=0 and `rx_chk_en_o`=0. `tx_fifo_wr_o`, `tx_rdy_o` and `tx_idle_o` pass through.
- R8: In an echo mode, an edge with `rx_break_i` high and `rx_start_i` low sets a break hold, and `txd_o`=0 while the hold is set. An edge with `rx_start_i` high, or with a non-echo mode active, clears the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_cfg_i | input | 2 | Requested mode |
| tx_busy_i | input | 1 | Transmitter is sending a character |
| rx_busy_i | input | 1 | Receiver is assembling a character |
| rxd_i | input | 1 | Serial input pin |
| txd_o | output | 1 | Serial output pin |
| tx_ser_i | input | 1 | Transmitter core serial output |
| tx_tick_i | input | 1 | Transmitter 1x bit enable |
| rx_tick_i | input | 1 | Receiver 1x bit enable at bit centre |
| rx_ser_o | output | 1 | Serial input to receiver core |
| rx_tick_o | output | 1 | Bit enable to receiver core |
| rx_break_i | input | 1 | Receiver detected a break |
| rx_start_i | input | 1 | Receiver detected a valid start bit |
| cpu_tx_wr_i | input | 1 | CPU write to transmit FIFO |
| tx_fifo_wr_o | output | 1 | Gated transmit FIFO write |
| tx_rdy_i | input | 1 | Transmitter ready flag |
| tx_idle_i | input | 1 | Transmitter idle flag |
| tx_rdy_o | output | 1 | Transmitter ready flag to CPU |
| tx_idle_o | output | 1 | Transmitter idle flag to CPU |
| rx_push_i | input | 1 | Receiver character strobe |
| rx_push_o | output | 1 | Gated receive FIFO push |
| rx_err_i | input | ERR_W | Receiver error flags |
| rx_err_o | output | ERR_W | Gated error flags |
| rx_chk_en_o | output | 1 | Parity/framing check enable |
| mode_o | output | 2 | Active mode |

## Verification
On every cycle, the assertions check that the mode stays put while either core is busy. They also check that local loop keeps the pin at mark, that automatic echo suppresses the CPU write and the transmitter flags, and that remote loop suppresses delivery and error reporting. They check as well that a break forces the echoed line low on the next cycle. Only the bench scenarios show the one-bit echo delay with its mark reset value, the release of the break hold on a start bit, the rerouting of the bit clocks, and the deferral of a mode request until both cores go idle.

// File: rtl/uart_lr_pkg.sv
package uart_lr_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL      = 2'b00,
    MODE_AUTO_ECHO   = 2'b01,
    MODE_LOCAL_LOOP  = 2'b10,
    MODE_REMOTE_LOOP = 2'b11
  } lr_mode_e;
endpackage

// File: rtl/uart_lr_mode_ctl.sv
module uart_lr_mode_ctl
  import uart_lr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_cfg_i,
  input  logic       tx_busy_i,
  input  logic       rx_busy_i,
  output lr_mode_e   mode_o
);
  lr_mode_e mode_q;

  // deferred switch: only between characters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       mode_q <= MODE_NORMAL;
    else if (!tx_busy_i && !rx_busy_i) mode_q <= lr_mode_e'(mode_cfg_i);
  end

  assign mode_o = mode_q;

  a_r2_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_i || rx_busy_i) |=> $stable(mode_o));
endmodule

// File: rtl/uart_lr_echo.sv
module uart_lr_echo (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rxd_i,
  input  logic rx_tick_i,
  input  logic rx_break_i,
  input  logic rx_start_i,
  output logic echo_txd_o
);
  logic samp_q, echo_q, hold_q;

  // centre sample, then one bit period later onto the line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b1;
      echo_q <= 1'b1;
    end else if (rx_tick_i) begin
      samp_q <= rxd_i;
      echo_q <= samp_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= 1'b0;
    else if (!en_i)      hold_q <= 1'b0;
    else if (rx_start_i) hold_q <= 1'b0;
    else if (rx_break_i) hold_q <= 1'b1;
  end

  assign echo_txd_o = hold_q ? 1'b0 : echo_q;

  a_r8_break_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rx_break_i && !rx_start_i) |=> !echo_txd_o);
endmodule

// File: rtl/uart_lr_mux.sv
module uart_lr_mux
  import uart_lr_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  lr_mode_e         mode_i,
  input  logic             rxd_i,
  input  logic             echo_txd_i,
  input  logic             tx_ser_i,
  input  logic             tx_tick_i,
  input  logic             rx_tick_i,
  input  logic             cpu_tx_wr_i,
  input  logic             tx_rdy_i,
  input  logic             tx_idle_i,
  input  logic             rx_push_i,
  input  logic [ERR_W-1:0] rx_err_i,
  output logic             txd_o,
  output logic             rx_ser_o,
  output logic             rx_tick_o,
  output logic             tx_fifo_wr_o,
  output logic             tx_rdy_o,
  output logic             tx_idle_o,
  output logic             rx_push_o,
  output logic [ERR_W-1:0] rx_err_o,
  output logic             rx_chk_en_o
);
  always_comb begin
    txd_o        = tx_ser_i;
    rx_ser_o     = rxd_i;
    rx_tick_o    = rx_tick_i;
    tx_fifo_wr_o = cpu_tx_wr_i;
    tx_rdy_o     = tx_rdy_i;
    tx_idle_o    = tx_idle_i;
    rx_push_o    = rx_push_i;
    rx_err_o     = rx_err_i;
    rx_chk_en_o  = 1'b1;
    unique case (mode_i)
      MODE_NORMAL: ;
      MODE_AUTO_ECHO: begin
        txd_o        = echo_txd_i;
        tx_fifo_wr_o = 1'b0;
        tx_rdy_o     = 1'b0;
        tx_idle_o    = 1'b0;
      end
      MODE_LOCAL_LOOP: begin
        txd_o     = 1'b1;
        rx_ser_o  = tx_ser_i;
        rx_tick_o = tx_tick_i;
      end
      MODE_REMOTE_LOOP: begin
        txd_o       = echo_txd_i;
        rx_push_o   = 1'b0;
        rx_err_o    = '0;
        rx_chk_en_o = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uart_loop_router.sv
module uart_loop_router
  import uart_lr_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_cfg_i,
  input  logic             tx_busy_i,
  input  logic             rx_busy_i,
  input  logic             rxd_i,
  output logic             txd_o,
  input  logic             tx_ser_i,
  input  logic             tx_tick_i,
  input  logic             rx_tick_i,
  output logic             rx_ser_o,
  output logic             rx_tick_o,
  input  logic             rx_break_i,
  input  logic             rx_start_i,
  input  logic             cpu_tx_wr_i,
  output logic             tx_fifo_wr_o,
  input  logic             tx_rdy_i,
  input  logic             tx_idle_i,
  output logic             tx_rdy_o,
  output logic             tx_idle_o,
  input  logic             rx_push_i,
  output logic             rx_push_o,
  input  logic [ERR_W-1:0] rx_err_i,
  output logic [ERR_W-1:0] rx_err_o,
  output logic             rx_chk_en_o,
  output logic [1:0]       mode_o
);
  lr_mode_e mode_q;
  logic     echo_en, echo_txd;

  uart_lr_mode_ctl i_mode_ctl (
    .clk_i, .rst_ni, .mode_cfg_i, .tx_busy_i, .rx_busy_i, .mode_o(mode_q)
  );

  assign echo_en = (mode_q == MODE_AUTO_ECHO) || (mode_q == MODE_REMOTE_LOOP);

  uart_lr_echo i_echo (
    .clk_i, .rst_ni, .en_i(echo_en), .rxd_i, .rx_tick_i,
    .rx_break_i, .rx_start_i, .echo_txd_o(echo_txd)
  );

  uart_lr_mux #(.ERR_W(ERR_W)) i_mux (
    .mode_i(mode_q), .rxd_i, .echo_txd_i(echo_txd), .tx_ser_i, .tx_tick_i,
    .rx_tick_i, .cpu_tx_wr_i, .tx_rdy_i, .tx_idle_i, .rx_push_i, .rx_err_i,
    .txd_o, .rx_ser_o, .rx_tick_o, .tx_fifo_wr_o, .tx_rdy_o, .tx_idle_o,
    .rx_push_o, .rx_err_o, .rx_chk_en_o
  );

  assign mode_o = mode_q;

  a_r4_local_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_LOCAL_LOOP) |-> txd_o);
  a_r6_echo_cpu_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_AUTO_ECHO) |-> (!tx_fifo_wr_o && !tx_rdy_o && !tx_idle_o));
  a_r7_remote_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_REMOTE_LOOP) |-> (!rx_push_o && rx_err_o == '0 && !rx_chk_en_o));
endmodule

// File: tb/test_uart_loop_router.sv
module test_uart_loop_router;
  localparam int ERR_W = 3;
  localparam int NCYC  = 4000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] mode_cfg_i = 2'b00;
  logic tx_busy_i = 0, rx_busy_i = 0, rxd_i = 1, tx_ser_i = 1, tx_tick_i = 0, rx_tick_i = 0;
  logic rx_break_i = 0, rx_start_i = 0, cpu_tx_wr_i = 0, tx_rdy_i = 0, tx_idle_i = 0, rx_push_i = 0;
  logic [ERR_W-1:0] rx_err_i = '0;
  logic txd_o, rx_ser_o, rx_tick_o, tx_fifo_wr_o, tx_rdy_o, tx_idle_o, rx_push_o, rx_chk_en_o;
  logic [ERR_W-1:0] rx_err_o;
  logic [1:0] mode_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [1:0] m_mode = 2'b00;
  logic m_samp = 1, m_echo = 1, m_hold = 0;

  always #5 clk_i = ~clk_i;

  uart_loop_router #(.ERR_W(ERR_W)) i_uart_loop_router (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_req(logic [1:0] m);
    case (m)
      2'b00: return "R3";
      2'b01: return "R6";
      2'b10: return "R4";
      default: return "R7";
    endcase
  endfunction

  function automatic logic exp_txd();
    case (m_mode)
      2'b00: return tx_ser_i;
      2'b10: return 1'b1;
      default: return m_hold ? 1'b0 : m_echo;
    endcase
  endfunction

  task automatic check_all(string mreq);
    string r = mode_req(m_mode);
    chk(mreq, 8'(mode_o), 8'(m_mode));
    chk((m_mode == 2'b00) ? "R3" : (m_mode == 2'b10) ? "R4" : (m_hold ? "R8" : "R5"),
        8'(txd_o), 8'(exp_txd()));
    chk((m_mode == 2'b10) ? "R4" : "R5", 8'(rx_ser_o), 8'((m_mode == 2'b10) ? tx_ser_i : rxd_i));
    chk((m_mode == 2'b10) ? "R4" : "R5", 8'(rx_tick_o), 8'((m_mode == 2'b10) ? tx_tick_i : rx_tick_i));
    chk(r, 8'(tx_fifo_wr_o), 8'((m_mode == 2'b01) ? 1'b0 : cpu_tx_wr_i));
    chk(r, 8'(tx_rdy_o), 8'((m_mode == 2'b01) ? 1'b0 : tx_rdy_i));
    chk(r, 8'(tx_idle_o), 8'((m_mode == 2'b01) ? 1'b0 : tx_idle_i));
    chk(r, 8'(rx_push_o), 8'((m_mode == 2'b11) ? 1'b0 : rx_push_i));
    chk(r, 8'(rx_err_o), 8'((m_mode == 2'b11) ? '0 : rx_err_i));
    chk(r, 8'(rx_chk_en_o), 8'(m_mode != 2'b11));
  endtask

  task automatic model_edge();
    if (m_mode == 2'b01 || m_mode == 2'b11) begin
      if (rx_start_i) m_hold = 0;
      else if (rx_break_i) m_hold = 1;
    end else m_hold = 0;
    if (rx_tick_i) begin
      m_echo = m_samp;
      m_samp = rxd_i;
    end
    if (!tx_busy_i && !rx_busy_i) m_mode = mode_cfg_i;
  endtask

  task automatic randomize_inputs(int phase);
    rxd_i       = 1'($urandom_range(0, 1));
    tx_ser_i    = 1'($urandom_range(0, 1));
    tx_tick_i   = ($urandom_range(0, 3) == 0);
    rx_tick_i   = ($urandom_range(0, 3) == 0);
    rx_break_i  = ($urandom_range(0, 39) == 0);
    rx_start_i  = ($urandom_range(0, 29) == 0);
    cpu_tx_wr_i = 1'($urandom_range(0, 1));
    tx_rdy_i    = 1'($urandom_range(0, 1));
    tx_idle_i   = 1'($urandom_range(0, 1));
    rx_push_i   = 1'($urandom_range(0, 1));
    rx_err_i    = ERR_W'($urandom);
    tx_busy_i   = ($urandom_range(0, 2) == 0);
    rx_busy_i   = ($urandom_range(0, 2) == 0);
    if (phase == 0 && $urandom_range(0, 59) == 0) mode_cfg_i = 2'($urandom_range(0, 3));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // reset state, R1
    repeat (2) begin
      @(negedge clk_i);
      tx_ser_i = ~tx_ser_i;
      mode_cfg_i = 2'b11;
      #2;
      chk("R1", 8'(mode_o), 8'h00);
      chk("R1", 8'(txd_o), 8'(tx_ser_i));
    end
    mode_cfg_i = 2'b00;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed R2: request local loop while busy, expect deferral
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      mode_cfg_i = 2'b10; tx_busy_i = (i < 3); rx_busy_i = (i == 1);
      #2; check_all("R2"); model_edge();
    end
    // directed R4: toggle rxd in local loop, pin must stay marking
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      tx_busy_i = 0; rx_busy_i = 0; rxd_i = i[0]; tx_ser_i = i[1]; tx_tick_i = i[0];
      #2; check_all("R4"); model_edge();
    end
    // directed R5/R8: automatic echo, break then start
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      mode_cfg_i = 2'b01; rx_tick_i = (i % 2 == 0); rxd_i = (i % 6 < 3);
      rx_break_i = (i == 9); rx_start_i = (i == 15);
      #2; check_all("R5"); model_edge();
    end
    rx_break_i = 0; rx_start_i = 0;

    // constrained random
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk_i);
      randomize_inputs(0);
      #2; check_all("R2"); model_edge();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule